// File: doc/BRIEF.md
# Ring Work-Stealing Search Coordinator

The block runs a depth-first tree search across a ring of workers. Each worker keeps a local stack of work packages and treats it as a double-ended queue. The worker takes and adds packages at the top end. An idle worker refills itself from the bottom end of its ring predecessor. A start pulse places one root package on worker 0, and every other worker gets its work by stealing. The search ends in one of two ways. A consumed package can match a masked target, and the block then reports success and the winning worker. Or every stack can drain, and the block then reports failure.

The search itself is a stub. A package carries a level and an identifier. Consuming a package at level L>0 replaces it with two children at level L-1, so the tree's shape is fixed by the root alone. A package at level 0 is simply removed. The stub makes every package the search creates visible at the ports, so a bench can show that each package is consumed exactly once.

Top module: `ws_ring`

## Requirements
- R1: After reset the block is idle: busy_o, done_o and found_o are 0 and no worker reports a consumption.
- R2: A start_i pulse while not busy clears all stacks and places the root package at stack position 0 of worker 0. In the first busy cycle, only worker 0 consumes, and it consumes the root. A start_i pulse while busy is ignored.
- R3: While busy, each non-empty worker consumes its top package once per cycle. A package with level L>0 and identifier i is replaced by two packages of level L-1. The identifier 2i goes below and 2i+1 goes on top, both truncated to the identifier width. A level-0 package is removed.
- R4: An empty worker w may only steal from worker (w-1) mod N. It copies the victim's bottom package into the same stack position of its own stack and makes that package its only entry. It consumes that package in the next cycle.
- R5: No steal takes place while the victim holds exactly one package. The thief retries in later cycles.
- R6: In a steal cycle, the victim still consumes its own top package, and its bottom advances by one.
- R7: Across all workers, every package the search creates is consumed exactly once. For a tree that is never cut short, this is 2^(L+1)-1 packages for a root at level L.
- R8: When every stack is empty during a busy cycle, the next cycle shows done_o=1 and found_o=0. A level-0 root drains after one consumption.
- R9: A consumed package matches when ((id ^ target_i) & mask_i) == 0. The cycle after a match, done_o=1 and found_o=1. winner_o then holds the lowest-index worker that matched, and result_lvl_o/result_id_o hold that worker's package.
- R10: While done, no worker consumes and the result holds. A new start_i pulse restarts the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a search (ignored while busy) |
| root_lvl_i | input | 4 | Level of the root package |
| root_id_i | input | 16 | Identifier of the root package |
| target_i | input | 16 | Identifier pattern that ends the search |
| mask_i | input | 16 | Bits of target_i that take part in the match |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished |
| found_o | output | 1 | Finished with a match |
| winner_o | output | 2 | Worker that produced the match |
| result_lvl_o | output | 4 | Level of the matching package |
| result_id_o | output | 16 | Identifier of the matching package |
| cons_vld_o | output | N_WORKERS | Per worker: a package is consumed this cycle |
| cons_flat_o | output | N_WORKERS*20 | Per worker: consumed package {level, id}, worker w at bits [w*20 +: 20] |

## Verification
The bench builds the block with its defaults: four workers, 16-entry stacks and 16-bit identifiers. With four workers, a steal can wrap from worker 3 to worker 0, and the priority rule can choose a winner other than worker 0. The 16-entry depth allows a level-15 root, which fills a stack to its last slot and creates all 65535 packages within the 16-bit identifier range. Short directed trees make the single-package postponement and the first steal visible at known cycles.

// File: rtl/ws_pkg.sv
package ws_pkg;
    localparam int unsigned ID_W      = 16;
    localparam int unsigned STK_DEPTH = 16;
    localparam int unsigned LVL_W     = $clog2(STK_DEPTH);
    localparam int unsigned IDX_W     = $clog2(STK_DEPTH);
    localparam int unsigned PTR_W     = $clog2(STK_DEPTH + 1);
    localparam int unsigned PKG_W     = LVL_W + ID_W;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [ID_W-1:0]  id;
    } pkg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ring_state_e;

    function automatic pkg_t child_of(pkg_t parent, logic odd);
        pkg_t c;
        c.lvl = parent.lvl - 1'b1;
        c.id  = {parent.id[ID_W-2:0], odd};
        return c;
    endfunction
endpackage

// File: rtl/ws_worker.sv
module ws_worker
    import ws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             load_i,
    input  logic             seed_i,
    input  pkg_t             load_pkg_i,
    input  logic [PTR_W-1:0] pred_bos_i,
    input  pkg_t             pred_bot_i,
    input  logic             pred_avail_i,
    input  logic             succ_take_i,
    output logic [PTR_W-1:0] bos_o,
    output pkg_t             bot_o,
    output logic             avail_o,
    output logic             take_o,
    output logic             empty_o,
    output logic             cons_vld_o,
    output pkg_t             cons_pkg_o
);
    pkg_t             mem [STK_DEPTH];
    logic [PTR_W-1:0] bos_q, tos_q;
    logic [PTR_W-1:0] fill;
    logic [IDX_W-1:0] top_idx;
    logic             expand;

    assign fill       = tos_q - bos_q;
    assign top_idx    = IDX_W'(tos_q - 1'b1);
    assign empty_o    = (tos_q == bos_q);
    assign cons_vld_o = run_i && !empty_o;
    assign cons_pkg_o = mem[top_idx];
    assign expand     = cons_vld_o && (cons_pkg_o.lvl != '0);
    assign bos_o      = bos_q;
    assign bot_o      = mem[bos_q[IDX_W-1:0]];
    // a lone package is being consumed by its owner, so it is not offered
    assign avail_o    = run_i && (fill >= PTR_W'(2));
    assign take_o     = run_i && empty_o && pred_avail_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            bos_q <= '0;
            tos_q <= '0;
        end else if (load_i) begin
            bos_q <= '0;
            tos_q <= seed_i ? PTR_W'(1) : '0;
        end else begin
            if (cons_vld_o)
                tos_q <= expand ? tos_q + 1'b1 : tos_q - 1'b1;
            if (take_o) begin
                bos_q <= pred_bos_i;
                tos_q <= pred_bos_i + 1'b1;
            end
            if (succ_take_i)
                bos_q <= bos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load_i) begin
            if (seed_i)
                mem[0] <= load_pkg_i;
        end else begin
            if (expand) begin
                mem[top_idx]                   <= child_of(cons_pkg_o, 1'b0);
                mem[IDX_W'(top_idx + 1'b1)]    <= child_of(cons_pkg_o, 1'b1);
            end
            if (take_o)
                mem[pred_bos_i[IDX_W-1:0]] <= pred_bot_i;
        end
    end

    // R3: pointers stay ordered and inside the stack
    a_r3_stack_bound: assert property (@(posedge clk) disable iff (rst)
        (tos_q <= PTR_W'(STK_DEPTH)) && (bos_q <= tos_q));
    // R5: the successor only takes from this stack when two or more remain
    a_r5_single_kept: assert property (@(posedge clk) disable iff (rst)
        succ_take_i |-> (fill >= PTR_W'(2)));
    // R4: a steal leaves exactly the stolen package at the victim's position
    a_r4_steal_lands: assert property (@(posedge clk) disable iff (rst)
        take_o |=> ((tos_q == bos_q + 1'b1) && (bos_q == $past(pred_bos_i))));
endmodule

// File: rtl/ws_arbiter.sv
module ws_arbiter
    import ws_pkg::*;
#(
    parameter int unsigned N_WORKERS = 4,
    localparam int unsigned WID_W    = (N_WORKERS > 1) ? $clog2(N_WORKERS) : 1
)(
    input  logic [N_WORKERS-1:0] hit_i,
    input  logic [N_WORKERS-1:0] empty_i,
    input  pkg_t [N_WORKERS-1:0] pkgs_i,
    output logic                 any_hit_o,
    output logic                 all_empty_o,
    output logic [WID_W-1:0]     win_idx_o,
    output pkg_t                 win_pkg_o
);
    always_comb begin
        win_idx_o = '0;
        win_pkg_o = '0;
        for (int i = N_WORKERS - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                win_idx_o = WID_W'(i);
                win_pkg_o = pkgs_i[i];
            end
        end
    end

    assign any_hit_o   = |hit_i;
    assign all_empty_o = &empty_i;
endmodule

// File: rtl/ws_ring.sv
module ws_ring
    import ws_pkg::*;
#(
    parameter int unsigned N_WORKERS = 4,
    localparam int unsigned WID_W    = (N_WORKERS > 1) ? $clog2(N_WORKERS) : 1
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [LVL_W-1:0]             root_lvl_i,
    input  logic [ID_W-1:0]              root_id_i,
    input  logic [ID_W-1:0]              target_i,
    input  logic [ID_W-1:0]              mask_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         found_o,
    output logic [WID_W-1:0]             winner_o,
    output logic [LVL_W-1:0]             result_lvl_o,
    output logic [ID_W-1:0]              result_id_o,
    output logic [N_WORKERS-1:0]         cons_vld_o,
    output logic [N_WORKERS*PKG_W-1:0]   cons_flat_o
);
    ring_state_e      state_q;
    logic             run, load;
    logic             found_q;
    logic [WID_W-1:0] winner_q;
    pkg_t             result_q;
    pkg_t             root_pkg;

    logic [N_WORKERS-1:0] empty, avail, take, hit;
    logic [PTR_W-1:0]     bos   [N_WORKERS];
    pkg_t                 bot   [N_WORKERS];
    pkg_t [N_WORKERS-1:0] cons_pkg;

    logic             any_hit, all_empty;
    logic [WID_W-1:0] win_idx;
    pkg_t             win_pkg;

    assign run          = (state_q == ST_RUN);
    assign load         = start_i && !run;
    assign root_pkg.lvl = root_lvl_i;
    assign root_pkg.id  = root_id_i;

    for (genvar w = 0; w < N_WORKERS; w++) begin : g_wrk
        localparam int unsigned PRED = (w + N_WORKERS - 1) % N_WORKERS;
        localparam int unsigned SUCC = (w + 1) % N_WORKERS;

        ws_worker u_worker (
            .clk          (clk),
            .rst          (rst),
            .run_i        (run),
            .load_i       (load),
            .seed_i       (w == 0),
            .load_pkg_i   (root_pkg),
            .pred_bos_i   (bos[PRED]),
            .pred_bot_i   (bot[PRED]),
            .pred_avail_i (avail[PRED]),
            .succ_take_i  (take[SUCC]),
            .bos_o        (bos[w]),
            .bot_o        (bot[w]),
            .avail_o      (avail[w]),
            .take_o       (take[w]),
            .empty_o      (empty[w]),
            .cons_vld_o   (cons_vld_o[w]),
            .cons_pkg_o   (cons_pkg[w])
        );

        assign hit[w] = cons_vld_o[w] && (((cons_pkg[w].id ^ target_i) & mask_i) == '0);
        assign cons_flat_o[w*PKG_W +: PKG_W] = cons_pkg[w];
    end

    ws_arbiter #(.N_WORKERS(N_WORKERS)) u_arb (
        .hit_i       (hit),
        .empty_i     (empty),
        .pkgs_i      (cons_pkg),
        .any_hit_o   (any_hit),
        .all_empty_o (all_empty),
        .win_idx_o   (win_idx),
        .win_pkg_o   (win_pkg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            found_q  <= 1'b0;
            winner_q <= '0;
            result_q <= '0;
        end else if (load) begin
            state_q  <= ST_RUN;
            found_q  <= 1'b0;
            winner_q <= '0;
            result_q <= '0;
        end else if (run) begin
            if (any_hit) begin
                state_q  <= ST_DONE;
                found_q  <= 1'b1;
                winner_q <= win_idx;
                result_q <= win_pkg;
            end else if (all_empty) begin
                state_q  <= ST_DONE;
            end
        end
    end

    assign busy_o       = run;
    assign done_o       = (state_q == ST_DONE);
    assign found_o      = found_q;
    assign winner_o     = winner_q;
    assign result_lvl_o = result_q.lvl;
    assign result_id_o  = result_q.id;

    // R8: a drained ring finishes without a match
    a_r8_fail_done: assert property (@(posedge clk) disable iff (rst)
        (run && all_empty && !any_hit) |=> (done_o && !found_o));
    // R9: a match finishes the search and records the arbitrated worker
    a_r9_hit_found: assert property (@(posedge clk) disable iff (rst)
        (run && any_hit) |=> (found_o && (winner_o == $past(win_idx))));
    // R10: nothing is consumed once the search has finished
    a_r10_quiet_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cons_vld_o == '0));
    // R2: a start pulse during a search does not end it
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (run && start_i && !any_hit && !all_empty) |=> busy_o);
endmodule

// File: tb/test_ws_ring.sv
module test_ws_ring;
    localparam int CLK_PERIOD = 10;
    localparam int NW   = 4;
    localparam int SD   = 16;
    localparam int IDW  = 16;
    localparam int LW   = 4;
    localparam int EW   = IDW + LW;
    localparam int WDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [LW-1:0]  root_lvl_i = '0;
    logic [IDW-1:0] root_id_i = '0, target_i = '0, mask_i = '0;
    logic busy_o, done_o, found_o;
    logic [1:0] winner_o;
    logic [LW-1:0] result_lvl_o;
    logic [IDW-1:0] result_id_o;
    logic [NW-1:0] cons_vld_o;
    logic [NW*EW-1:0] cons_flat_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ws_ring #(.N_WORKERS(NW)) i_ws_ring (
        .clk(clk), .rst(rst), .start_i(start_i), .root_lvl_i(root_lvl_i),
        .root_id_i(root_id_i), .target_i(target_i), .mask_i(mask_i),
        .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .winner_o(winner_o),
        .result_lvl_o(result_lvl_o), .result_id_o(result_id_o),
        .cons_vld_o(cons_vld_o), .cons_flat_o(cons_flat_o)
    );

    int nchk = 0, nerr = 0;

    // reference model state
    bit [EW-1:0] mstk [NW][SD];
    int mbos [NW];
    int mtos [NW];
    int mst = 0;
    bit mfound = 0;
    int mwin = 0;
    bit [EW-1:0] mres = '0;
    int seen [int];
    int cons_total = 0;
    int used [NW];

    // stimulus for the next cycle
    bit s_start = 0;
    bit [LW-1:0] s_lvl = '0;
    bit [IDW-1:0] s_id = '0, s_tgt = '0, s_msk = '0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        seen.delete();
        cons_total = 0;
        for (int w = 0; w < NW; w++) used[w] = 0;
    endtask

    task automatic tick();
        bit [EW-1:0] ostk [NW][SD];
        int obos [NW];
        int otos [NW];
        int cnt [NW];
        bit pv [NW];
        bit [EW-1:0] pe [NW];
        bit run;
        int hitw;
        bit allempty;
        @(negedge clk);
        start_i = s_start; root_lvl_i = s_lvl; root_id_i = s_id;
        target_i = s_tgt; mask_i = s_msk;
        #1;
        run = (mst == 1);
        for (int w = 0; w < NW; w++) begin
            cnt[w] = mtos[w] - mbos[w];
            pv[w] = run && cnt[w] > 0;
            pe[w] = pv[w] ? mstk[w][mtos[w]-1] : '0;
        end
        chk(busy_o == run, "R2/R10 busy", busy_o, run);
        chk(done_o == (mst == 2), "R8/R10 done", done_o, mst == 2);
        chk(found_o == mfound, "R9 found", found_o, mfound);
        if (mfound) begin
            chk(winner_o == mwin, "R9 winner", winner_o, mwin);
            chk({result_lvl_o, result_id_o} == mres, "R9 result", {result_lvl_o, result_id_o}, mres);
        end
        for (int w = 0; w < NW; w++) begin
            chk(cons_vld_o[w] == pv[w], "R3/R4 consume valid", cons_vld_o[w], pv[w]);
            if (pv[w])
                chk(cons_flat_o[w*EW +: EW] == pe[w], "R3 consumed package", cons_flat_o[w*EW +: EW], pe[w]);
        end
        // next state
        ostk = mstk; obos = mbos; otos = mtos;
        if (s_start && mst != 1) begin
            mst = 1; mfound = 0; mwin = 0; mres = '0;
            for (int w = 0; w < NW; w++) begin mbos[w] = 0; mtos[w] = 0; end
            mstk[0][0] = {s_lvl, s_id};
            mtos[0] = 1;
        end else if (run) begin
            hitw = -1;
            allempty = 1;
            for (int w = 0; w < NW; w++) begin
                int pr;
                pr = (w + NW - 1) % NW;
                if (cnt[w] > 0) allempty = 0;
                if (pv[w]) begin
                    bit [IDW-1:0] id;
                    bit [LW-1:0] lv;
                    id = pe[w][IDW-1:0];
                    lv = pe[w][EW-1:IDW];
                    cons_total++;
                    used[w]++;
                    if (seen.exists(int'(id))) seen[int'(id)]++; else seen[int'(id)] = 1;
                    if (hitw < 0 && ((id ^ s_tgt) & s_msk) == 0) hitw = w;
                    if (lv != 0) begin
                        mstk[w][otos[w]-1] = {lv - 4'd1, id[IDW-2:0], 1'b0};
                        mstk[w][otos[w]]   = {lv - 4'd1, id[IDW-2:0], 1'b1};
                        mtos[w] = otos[w] + 1;
                    end else begin
                        mtos[w] = otos[w] - 1;
                    end
                end else if (cnt[w] == 0 && (otos[pr] - obos[pr]) >= 2) begin
                    mstk[w][obos[pr]] = ostk[pr][obos[pr]];
                    mbos[w] = obos[pr];
                    mtos[w] = obos[pr] + 1;
                    mbos[pr] = obos[pr] + 1;
                end
            end
            if (hitw >= 0) begin
                mst = 2; mfound = 1; mwin = hitw; mres = pe[hitw];
            end else if (allempty) begin
                mst = 2;
            end
        end
    endtask

    task automatic launch(bit [LW-1:0] lv, bit [IDW-1:0] id, bit [IDW-1:0] tg, bit [IDW-1:0] mk);
        s_lvl = lv; s_id = id; s_tgt = tg; s_msk = mk; s_start = 1;
        clear_stats();
        tick();
        s_start = 0;
    endtask

    task automatic run_to_done();
        int n;
        n = 0;
        while (!(mst == 2) && n < WDOG) begin tick(); n++; end
        tick();
        if (n >= WDOG) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual %0d expected below %0d", n, WDOG);
        end
    endtask

    task automatic check_once(string req, int expect_total);
        bit dup;
        dup = 0;
        foreach (seen[k]) if (seen[k] != 1) dup = 1;
        chk(cons_total == expect_total, req, cons_total, expect_total);
        chk(!dup && seen.num() == expect_total, req, seen.num(), expect_total);
    endtask

    initial begin
        for (int w = 0; w < NW; w++) begin mbos[w] = 0; mtos[w] = 0; used[w] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle state after reset
        tick();
        chk(!busy_o && !done_o && !found_o, "R1 reset state", {busy_o, done_o, found_o}, 0);
        chk(cons_vld_o == '0, "R1 no consume", cons_vld_o, 0);

        // directed: root level 1 id 2, no match possible
        launch(4'd1, 16'd2, 16'h0000, 16'hFFFF);
        tick();  // cycle 1
        chk(cons_vld_o == 4'b0001, "R2 only worker 0 first", cons_vld_o, 1);
        chk(cons_flat_o[EW-1:0] == {4'd1, 16'd2}, "R2 root consumed", cons_flat_o[EW-1:0], {4'd1, 16'd2});
        tick();  // cycle 2: worker 1 held off in cycle 1 (R5), steals now
        chk(cons_vld_o == 4'b0001, "R5 no steal of single package", cons_vld_o, 1);
        chk(cons_flat_o[EW-1:0] == {4'd0, 16'd5}, "R3 odd child on top", cons_flat_o[EW-1:0], {4'd0, 16'd5});
        tick();  // cycle 3
        chk(cons_vld_o == 4'b0010, "R4 thief consumes stolen package", cons_vld_o, 2);
        chk(cons_flat_o[EW +: EW] == {4'd0, 16'd4}, "R4/R6 stolen bottom package", cons_flat_o[EW +: EW], {4'd0, 16'd4});
        tick();  // cycle 4: all empty
        tick();
        chk(done_o && !found_o, "R8 drained ring fails", {done_o, found_o}, 2);
        check_once("R7 exactly once small", 3);

        // R2 ignored restart, R7 count, R4 every worker takes part
        launch(4'd10, 16'd1, 16'h0000, 16'hFFFF);
        repeat (20) tick();
        s_lvl = 4'd2; s_id = 16'd9; s_start = 1;
        tick();
        s_start = 0;
        chk(busy_o, "R2 start ignored while busy", busy_o, 1);
        run_to_done();
        check_once("R7/R2 exactly once level 10", 2047);
        for (int w = 0; w < NW; w++)
            chk(used[w] > 0, "R4 ring steals reach every worker", used[w], 1);
        repeat (3) tick();
        chk(cons_vld_o == '0 && done_o, "R10 quiet when done", cons_vld_o, 0);

        // R9: worker 1 matches even id 6 first
        launch(4'd2, 16'd3, 16'h0000, 16'h0001);
        run_to_done();
        chk(found_o && winner_o == 2'd1, "R9 winner worker 1", winner_o, 1);
        chk({result_lvl_o, result_id_o} == {4'd1, 16'd6}, "R9 result package", {result_lvl_o, result_id_o}, {4'd1, 16'd6});

        // R10 restart from done; R9 mask zero matches root at once
        launch(4'd5, 16'd7, 16'h1234, 16'h0000);
        run_to_done();
        chk(found_o && winner_o == 2'd0 && result_id_o == 16'd7, "R10/R9 restart and match root", result_id_o, 7);

        // R8 boundary: level-0 root
        launch(4'd0, 16'd3, 16'h0000, 16'hFFFF);
        run_to_done();
        chk(done_o && !found_o, "R8 level-0 root fails", {done_o, found_o}, 2);
        check_once("R7 exactly once level 0", 1);

        // R3/R7 boundary: level-15 root fills a stack
        launch(4'd15, 16'd1, 16'h0000, 16'hFFFF);
        run_to_done();
        check_once("R7/R3 exactly once level 15", 65535);

        // R9: priority among several workers through masked match
        launch(4'd9, 16'd1, 16'h0003, 16'h0003);
        run_to_done();
        chk(found_o, "R9 masked match found", found_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule